// File: doc/BRIEF.md
# Five-Oscillator Summing IQ Tone Generator

This block produces one complex baseband channel as the sum of several independent numerically controlled oscillators, five by default. Every oscillator owns a 32-bit phase accumulator, a frequency tuning word, a 16-bit phase offset, a 15-bit amplitude and a clear flag that holds the accumulator at zero. On each accepted sample enable, every oscillator looks up cosine and sine for its current phase in a shared 64-point table. The block scales each result by the oscillator's amplitude, adds the terms of all oscillators and saturates the total to a 14-bit signed I and Q pair.

Software reaches the oscillators through a plain register write strobe with a small address and a 32-bit data word. An even address loads a tuning word. An odd address loads a packed word that holds the amplitude, the clear flag and the phase offset in one access.

The sample output is a valid/ready stream. When the consumer does not accept a sample, the sample stays on the output unchanged. Any sample enable that arrives during the stall is dropped and no accumulator moves.

Top module: `msum_nco_channel`

## Requirements
- R1: After reset, `out_valid` is 0. Every tuning word is 0, every accumulator is 0, every clear flag is 0, every phase offset is 0 and every amplitude is full scale (0x7fff). The first sample after reset is therefore I = 8191, Q = 0.
- R2: A write to address 2·k loads the 32-bit tuning word of oscillator k. Each accepted sample uses the accumulator value it finds, and the accumulator then advances by the tuning word (modulo 2^32).
- R3: A write to address 2·k+1 sets oscillator k from the data word as follows:
  - bits 14:0 are the amplitude;
  - bit 15 is the clear flag;
  - bits 31:16 are the phase offset.
- R4: The oscillator phase is (accumulator bits 31:16 + phase offset) mod 2^16. Its top 6 bits select one of 64 equally spaced angles n·2π/64. I takes the cosine and Q takes the sine. The table holds round(32767·cos) for the first quarter wave, so 0° gives cosine 32767 and sine 0.
- R5: Each oscillator's term is floor(table value × amplitude / 2^15). An amplitude of 0 contributes nothing.
- R6: The terms of all oscillators are added, divided by 4 with floor, and clamped to [-8192, 8191] without wrapping.
- R7: Clear is persistent. A write that sets bit 15 zeroes the accumulator at once. While the flag stays set, the accumulator stays at zero and the output follows the phase offset only.
- R8: A register write takes effect from the first sample accepted after the write cycle. A sample accepted in the same cycle as the write uses the old values.
- R9: A write to an address of 2·N_OSC (10) or above changes nothing.
- R10: A sample is accepted when `smp_en` is high and either `out_valid` is low or `out_ready` is high. The sample appears with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, `out_i` and `out_q` hold their values, and an enable in that time is dropped without advancing any accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (oscillator index × 2 + word select) |
| reg_wdata | input | 32 | Register write data |
| smp_en | input | 1 | Request to produce the next sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_i | output | 14 | Summed in-phase sample, signed |
| out_q | output | 14 | Summed quadrature sample, signed |

## Verification
The bench builds the block with its defaults: five oscillators, 32-bit tuning words and a 14-bit output. With these values, five full-scale terms overrun the output range in both directions, so the clamp is exercised at each rail. A tuning word of 2^26 moves exactly one table step per sample, which makes neighbouring-angle samples exactly predictable. A table of single-oscillator phase and amplitude settings checks the four quadrants, the 45° points and the floor rounding. Two detuned oscillators are then compared against a real-valued model within a small tolerance.

// File: rtl/msnco_pkg.sv
package msnco_pkg;

  localparam int LUT_IDX_W = 6;   // 64 points per turn, quarter table of 17
  localparam int TRIG_W    = 16;

  // magnitude of cos(2*pi*k/64) for k = 0..16, full scale 32767
  function automatic logic [TRIG_W-1:0] quarter_mag(input logic [4:0] k);
    logic [TRIG_W-1:0] m;
    case (k)
      5'd0:  m = 16'd32767;
      5'd1:  m = 16'd32609;
      5'd2:  m = 16'd32137;
      5'd3:  m = 16'd31356;
      5'd4:  m = 16'd30273;
      5'd5:  m = 16'd28898;
      5'd6:  m = 16'd27245;
      5'd7:  m = 16'd25329;
      5'd8:  m = 16'd23170;
      5'd9:  m = 16'd20787;
      5'd10: m = 16'd18204;
      5'd11: m = 16'd15446;
      5'd12: m = 16'd12539;
      5'd13: m = 16'd9512;
      5'd14: m = 16'd6393;
      5'd15: m = 16'd3212;
      default: m = 16'd0;
    endcase
    return m;
  endfunction

  // signed cosine at angle index n (n * 2*pi/64) from the quarter table
  function automatic logic signed [TRIG_W-1:0] lut_cos(input logic [LUT_IDX_W-1:0] n);
    logic [4:0]        off;
    logic [TRIG_W-1:0] mag;
    off = {1'b0, n[3:0]};
    if (n[4]) off = 5'd16 - off;
    mag = quarter_mag(off);
    if (n[5] ^ n[4]) return -$signed(mag);
    return $signed(mag);
  endfunction

endpackage

// File: rtl/msnco_trig_lut.sv
module msnco_trig_lut
  import msnco_pkg::*;
(
  input  logic [LUT_IDX_W-1:0]     angle,
  output logic signed [TRIG_W-1:0] cos_o,
  output logic signed [TRIG_W-1:0] sin_o
);
  localparam logic [LUT_IDX_W-1:0] QUARTER = LUT_IDX_W'(1 << (LUT_IDX_W - 2));

  always_comb begin
    cos_o = lut_cos(angle);
    sin_o = lut_cos(angle - QUARTER);
  end
endmodule

// File: rtl/msnco_osc.sv
module msnco_osc
  import msnco_pkg::*;
#(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 15,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     wr_ftw,
  input  logic                     wr_ctl,
  input  logic [DATA_W-1:0]        wr_data,
  output logic signed [TRIG_W-1:0] term_i,
  output logic signed [TRIG_W-1:0] term_q
);
  localparam int CLR_BIT = AMP_W;
  localparam int POW_LSB = AMP_W + 1;
  localparam int PROD_W  = TRIG_W + AMP_W + 1;
  localparam int IDX_SH  = PHASE_W - LUT_IDX_W;

  logic [FTW_W-1:0]   ftw_q;
  logic [FTW_W-1:0]   acc_q;
  logic [AMP_W-1:0]   amp_q;
  logic [PHASE_W-1:0] pow_q;
  logic               clr_q;
  logic               clr_now;

  assign clr_now = wr_ctl && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_q <= '0;
      amp_q <= '1;
      pow_q <= '0;
      clr_q <= 1'b0;
    end else begin
      if (wr_ftw) ftw_q <= wr_data[FTW_W-1:0];
      if (wr_ctl) begin
        amp_q <= wr_data[AMP_W-1:0];
        clr_q <= wr_data[CLR_BIT];
        pow_q <= wr_data[POW_LSB +: PHASE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (clr_now)  acc_q <= '0;
    else if (take)     acc_q <= clr_q ? '0 : acc_q + ftw_q;
  end

  logic [PHASE_W-1:0]   phase;
  logic [LUT_IDX_W-1:0] angle;
  logic signed [TRIG_W-1:0] cos_v, sin_v;
  logic signed [PROD_W-1:0] prod_i, prod_q;

  assign phase = acc_q[FTW_W-1 -: PHASE_W] + pow_q;
  assign angle = LUT_IDX_W'(phase >> IDX_SH);

  msnco_trig_lut u_lut (
    .angle (angle),
    .cos_o (cos_v),
    .sin_o (sin_v)
  );

  assign prod_i = PROD_W'(cos_v) * $signed({1'b0, amp_q});
  assign prod_q = PROD_W'(sin_v) * $signed({1'b0, amp_q});
  assign term_i = TRIG_W'(prod_i >>> AMP_W);
  assign term_q = TRIG_W'(prod_q >>> AMP_W);

  AST_CLR_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q && $past(clr_q) |-> acc_q == '0); // R7
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !clr_q && !clr_now |=> acc_q == $past(acc_q + ftw_q)); // R2
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !wr_ctl |=> $stable(acc_q)); // R10
endmodule

// File: rtl/msnco_sum_sat.sv
module msnco_sum_sat #(
  parameter int N_TERMS = 5,
  parameter int IN_W    = 16,
  parameter int OUT_W   = 14
) (
  input  logic signed [IN_W-1:0]  terms [N_TERMS],
  output logic signed [OUT_W-1:0] result
);
  localparam int SUM_W = IN_W + $clog2(N_TERMS) + 1;
  localparam int DROP  = IN_W - OUT_W;
  localparam int HI_I  = 2 ** (OUT_W - 1) - 1;
  localparam int LO_I  = -(2 ** (OUT_W - 1));
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(HI_I);
  localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(LO_I);

  logic signed [SUM_W-1:0] part [N_TERMS+1];
  logic signed [SUM_W-1:0] scaled;

  assign part[0] = '0;
  for (genvar g = 0; g < N_TERMS; g++) begin : g_add
    assign part[g+1] = part[g] + {{(SUM_W-IN_W){terms[g][IN_W-1]}}, terms[g]};
  end

  assign scaled = part[N_TERMS] >>> DROP;

  always_comb begin
    if (scaled > HI_S)      result = OUT_W'(HI_I);
    else if (scaled < LO_S) result = OUT_W'(LO_I);
    else                    result = OUT_W'(scaled);
  end
endmodule

// File: rtl/msum_nco_channel.sv
module msum_nco_channel
  import msnco_pkg::*;
#(
  parameter int N_OSC   = 5,
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 15,
  parameter int OUT_W   = 14,
  parameter int DATA_W  = 32,
  localparam int ADDR_W = $clog2(2 * N_OSC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  input  logic                    smp_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  logic take;
  logic signed [TRIG_W-1:0] terms_i [N_OSC];
  logic signed [TRIG_W-1:0] terms_q [N_OSC];
  logic signed [OUT_W-1:0]  sum_i, sum_q;

  assign take = smp_en && (!out_valid || out_ready);

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    logic sel_ftw, sel_ctl;
    assign sel_ftw = reg_wr && (reg_addr == ADDR_W'(2 * g));
    assign sel_ctl = reg_wr && (reg_addr == ADDR_W'(2 * g + 1));

    msnco_osc #(
      .FTW_W   (FTW_W),
      .PHASE_W (PHASE_W),
      .AMP_W   (AMP_W),
      .DATA_W  (DATA_W)
    ) u_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .wr_ftw  (sel_ftw),
      .wr_ctl  (sel_ctl),
      .wr_data (reg_wdata),
      .term_i  (terms_i[g]),
      .term_q  (terms_q[g])
    );
  end

  msnco_sum_sat #(.N_TERMS(N_OSC), .IN_W(TRIG_W), .OUT_W(OUT_W)) u_sum_i (
    .terms  (terms_i),
    .result (sum_i)
  );
  msnco_sum_sat #(.N_TERMS(N_OSC), .IN_W(TRIG_W), .OUT_W(OUT_W)) u_sum_q (
    .terms  (terms_q),
    .result (sum_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_i     <= sum_i;
      out_q     <= sum_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q)); // R10
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && (!out_valid || out_ready) |=> out_valid); // R10
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en && out_valid && out_ready |=> !out_valid); // R10
endmodule

// File: tb/msum_nco_channel_tb_top.sv
module msum_nco_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic smp_en = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic signed [13:0] out_i, out_q;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msum_nco_channel dut_i (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .smp_en (smp_en), .out_valid (out_valid),
    .out_ready (out_ready), .out_i (out_i), .out_q (out_q)
  );

  // {phase offset, amplitude, expected I, expected Q}, oscillator 0 alone
  localparam logic [63:0] VEC [11] = '{
    {16'h0000, 16'h7fff, 16'd8191,  16'd0},
    {16'h4000, 16'h7fff, 16'd0,     16'd8191},
    {16'h8000, 16'h7fff, 16'hE000,  16'd0},
    {16'hC000, 16'h7fff, 16'd0,     16'hE000},
    {16'h2000, 16'h7fff, 16'd5792,  16'd5792},
    {16'h6000, 16'h7fff, 16'hE95F,  16'd5792},
    {16'h0400, 16'h7fff, 16'd8152,  16'd802},
    {16'h43FF, 16'h7fff, 16'd0,     16'd8191},
    {16'h0000, 16'h4000, 16'd4095,  16'd0},
    {16'h8000, 16'h4000, 16'hF000,  16'd0},
    {16'h0000, 16'h0000, 16'd0,     16'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input int ai, input int aq,
                            input int ei, input int eq);
    check(ai == ei, {req, " I"}, ai, ei);
    check(aq == eq, {req, " Q"}, aq, eq);
  endtask

  function automatic logic [31:0] ctl_word(input logic [15:0] pow, input bit clr,
                                           input logic [14:0] amp);
    return {pow, clr, amp};
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic take(output int si, output int sq);
    @(negedge clk);
    smp_en = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    check(out_valid == 1'b1, "R10 valid after take", int'(out_valid), 1);
    si = int'(out_i); sq = int'(out_q);
  endtask

  task automatic take_with_wr(input logic [3:0] a, input logic [31:0] d,
                              output int si, output int sq);
    @(negedge clk);
    smp_en = 1'b1; out_ready = 1'b1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    smp_en = 1'b0; reg_wr = 1'b0;
    si = int'(out_i); sq = int'(out_q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int ai, aq;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low after reset", int'(out_valid), 0);

    // R1 / R6: five full-scale defaults saturate I high
    take(ai, aq);
    check_pair("R1 R6 default sample", ai, aq, 8191, 0);

    // silence oscillators 1..4
    for (int k = 1; k < 5; k++) do_wr(4'(2 * k + 1), 32'h0);

    // R3 R4 R5: table of single-oscillator settings
    for (int v = 0; v < 11; v++) begin
      logic [63:0] e;
      e = VEC[v];
      do_wr(4'd1, ctl_word(e[63:48], 1'b0, e[46:32]));
      take(ai, aq);
      check_pair($sformatf("R3 R4 R5 vector %0d", v), ai, aq,
                 int'($signed(e[31:16])), int'($signed(e[15:0])));
    end

    // R6: five terms at 180 degrees saturate I low
    for (int k = 0; k < 5; k++) do_wr(4'(2 * k + 1), ctl_word(16'h8000, 1'b0, 15'h7fff));
    take(ai, aq);
    check_pair("R6 negative clamp", ai, aq, -8192, 0);
    for (int k = 1; k < 5; k++) do_wr(4'(2 * k + 1), 32'h0);
    do_wr(4'd1, ctl_word(16'h0000, 1'b0, 15'h7fff));

    // R9: out-of-range addresses
    do_wr(4'd10, 32'h4000_0000);
    do_wr(4'd11, ctl_word(16'h8000, 1'b0, 15'h7fff));
    do_wr(4'd15, ctl_word(16'h4000, 1'b0, 15'h7fff));
    take(ai, aq);
    check_pair("R9 ignored write 1st", ai, aq, 8191, 0);
    take(ai, aq);
    check_pair("R9 ignored write 2nd", ai, aq, 8191, 0);

    // R8: write concurrent with an accepted sample
    take_with_wr(4'd1, ctl_word(16'h4000, 1'b0, 15'h7fff), ai, aq);
    check_pair("R8 same-cycle old value", ai, aq, 8191, 0);
    take(ai, aq);
    check_pair("R8 next sample new value", ai, aq, 0, 8191);
    do_wr(4'd1, ctl_word(16'h0000, 1'b0, 15'h7fff));

    // R2 R7: one table step per sample, then persistent clear
    do_wr(4'd0, 32'h0400_0000);
    take(ai, aq);
    check_pair("R2 step 0", ai, aq, 8191, 0);
    take(ai, aq);
    check_pair("R2 step 1", ai, aq, 8152, 802);
    do_wr(4'd1, ctl_word(16'h0000, 1'b1, 15'h7fff));
    for (int s = 0; s < 3; s++) begin
      take(ai, aq);
      check_pair($sformatf("R7 held clear %0d", s), ai, aq, 8191, 0);
    end
    do_wr(4'd1, ctl_word(16'h0000, 1'b0, 15'h7fff));
    take(ai, aq);
    check_pair("R7 release from zero", ai, aq, 8191, 0);
    take(ai, aq);
    check_pair("R7 advance after release", ai, aq, 8152, 802);

    // R2 R4 R5: two detuned oscillators against a real-valued model
    begin
      logic [31:0] m_acc [2];
      logic [31:0] m_ftw [2];
      logic [15:0] m_pow [2];
      int          m_amp [2];
      m_ftw[0] = 32'h0C00_3039; m_pow[0] = 16'h0000; m_amp[0] = 'h5000;
      m_ftw[1] = 32'h0A3D_70A3; m_pow[1] = 16'h1234; m_amp[1] = 'h2000;
      for (int k = 0; k < 2; k++) begin
        do_wr(4'(2 * k + 1), ctl_word(m_pow[k], 1'b1, 15'(m_amp[k])));
        do_wr(4'(2 * k), m_ftw[k]);
        do_wr(4'(2 * k + 1), ctl_word(m_pow[k], 1'b0, 15'(m_amp[k])));
        m_acc[k] = '0;
      end
      for (int s = 0; s < 24; s++) begin
        real ei, eq, di, dq;
        ei = 0.0; eq = 0.0;
        for (int k = 0; k < 2; k++) begin
          logic [15:0] ph;
          real ang;
          ph = m_acc[k][31:16] + m_pow[k];
          ang = TWO_PI * real'(int'(ph[15:10])) / 64.0;
          ei += real'(m_amp[k]) * $cos(ang) / 32768.0 * 32767.0 / 32768.0 * 32768.0 / 32767.0;
          eq += real'(m_amp[k]) * $sin(ang) / 32768.0 * 32767.0 / 32768.0 * 32768.0 / 32767.0;
        end
        ei = ei * 32767.0 / 4.0; eq = eq * 32767.0 / 4.0;
        take(ai, aq);
        di = real'(ai) - ei; if (di < 0.0) di = -di;
        dq = real'(aq) - eq; if (dq < 0.0) dq = -dq;
        check(di <= 3.0, $sformatf("R2 R4 R5 model I sample %0d", s), ai, $rtoi(ei));
        check(dq <= 3.0, $sformatf("R2 R4 R5 model Q sample %0d", s), aq, $rtoi(eq));
        for (int k = 0; k < 2; k++) m_acc[k] = m_acc[k] + m_ftw[k];
      end
    end

    // R10: back-pressure holds the sample and drops enables
    do_wr(4'd1, ctl_word(16'h0000, 1'b1, 15'h7fff));
    do_wr(4'd0, 32'h0400_0000);
    do_wr(4'd1, ctl_word(16'h0000, 1'b0, 15'h7fff));
    do_wr(4'd3, 32'h0);
    @(negedge clk);
    out_ready = 1'b0; smp_en = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R10 valid under stall", int'(out_valid), 1);
    check_pair("R10 stalled sample", int'(out_i), int'(out_q), 8191, 0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
      check_pair("R10 sample held", int'(out_i), int'(out_q), 8191, 0);
    end
    smp_en = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", int'(out_valid), 0);
    take(ai, aq);
    check_pair("R10 single advance across stall", ai, aq, 8152, 802);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule